// File: doc/BRIEF.md
# Prioritized Address Window Chip-Select Decoder

This block sits between a processor's external access path and the bus sequencer. For every external access it compares the address against a set of programmable address windows. It picks the bus-control parameter set that belongs to the winning window and drives one active-low chip-select line for that access. Each window has a power-of-two size of 4 KB or more and a base aligned to that size. When windows overlap, the window with the higher index wins. An access that falls in no window uses control set 0 and its own default chip-select.

Software programs the windows, the control sets and one option bit through a small synchronous write port. The sequencer pulses `acc_start` with the address and later pulses `acc_end`. The block answers with the selected set index and its control word, an address-latch strobe, and the chip-select lines. The option bit sets where the chip-select edges fall. They can change on the same rising clock edge that raises the strobe, or half a clock later on the falling edge, which is the reset behaviour.

Top module: `addr_window_cs`

## Requirements
- R1: While `rst` is high and after it falls, until the first `acc_start`, all `cs_n` bits are 1, `lat_stb` is 0, `sel_idx` is 0 and `sel_ctrl` equals `RST_CTRL`. Every window is disabled, every control set holds `RST_CTRL`, and the edge option is 0.
- R2: Window w (1..NUM_WIN) has base B, size code s and enable bit e. It matches address A when e is 1 and A[ADDR_W-1:MIN_LOG2+s] equals B[ADDR_W-1:MIN_LOG2+s], so the window covers 2^(MIN_LOG2+s) bytes. Base bits below that boundary are ignored. A size code of ADDR_W-MIN_LOG2 or more covers the whole space, and a disabled window never matches.
- R3: An access that matches no window selects set 0 and drives `cs_n[0]` low.
- R4: Among matching windows the highest index wins. With four windows the order is 4, then 3, then 2, then 1, so 4 beats 3, 2 beats 1, and either of 3 and 4 beats either of 1 and 2. The winner drives `cs_n[w]` low.
- R5: The rising edge that samples `acc_start` loads `sel_idx` with the winner and `sel_ctrl` with that set's word. The word holds waits [3:0], bus-turnaround gap [4], long strobe [5], read/write delay [6], READY enable [7] and READY active level [8]. Both outputs hold until the next `acc_start`. At most one `cs_n` bit is ever low.
- R6: With the edge option 0, the chip-select change that an `acc_start` or `acc_end` causes appears on the falling clock edge after the rising edge that sampled it.
- R7: With the edge option 1, that chip-select change appears on the same rising edge that samples the request, which for a start is the edge where `lat_stb` rises.
- R8: An `acc_end` with no `acc_start` returns all `cs_n` bits and `lat_stb` to their idle levels. When both are sampled together, `acc_start` wins.
- R9: `lat_stb` rises on the edge that samples `acc_start`. It stays high for one cycle, or for two cycles when the selected set's long-strobe bit [5] is 1.
- R10: Write address map on `cfg_sel`. Addresses 0..NUM_WIN load control set k from `cfg_wdata[8:0]`. Address 8+(w-1) loads window w: base from `cfg_wdata[ADDR_W-1:MIN_LOG2]`, enable from bit 4, size code from bits [3:0]. Address 7 bit 0 is the edge option. All other addresses are ignored. A write is used by accesses that start after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_start | input | 1 | Start of an external access, address valid |
| acc_end | input | 1 | End of the current external access |
| acc_addr | input | ADDR_W | Access byte address |
| sel_idx | output | IDX_W | Index of selected control set (0 = default) |
| sel_ctrl | output | 9 | Selected bus-control word |
| lat_stb | output | 1 | Address-latch strobe |
| cs_n | output | NUM_WIN+1 | Active-low chip-selects, bit 0 is the default region |

## Verification
The bench uses the defaults: a 24-bit address, four windows and a 4 KB minimum window. Random window bases are confined to the low 256 KB and random size codes run from 0 to 5. Two, three or four windows therefore overlap often, and the full priority order gets exercised under mixed enable patterns. Directed cases add a whole-space window (size code 12), a base with ignored low bits, addresses one byte past a window's end and writes to unmapped addresses. Each access is sampled a quarter cycle and three quarters of a cycle after the start edge, so the two chip-select edge options are told apart.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int CTRL_W     = 9;
  localparam int SZ_W       = 4;
  localparam int SEL_EN_BIT = 4;
  localparam int CFG_AW     = 4;
  localparam logic [CFG_AW-1:0] CFG_OPT_ADDR = 4'd7;
  localparam int CFG_WIN_BASE = 8;

  typedef struct packed {
    logic       rdy_pol;
    logic       rdy_en;
    logic       rw_dly;
    logic       long_stb;
    logic       tri_gap;
    logic [3:0] waits;
  } bus_ctrl_t;
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 12,
  parameter logic [CTRL_W-1:0] RST_CTRL = 9'h00F,
  localparam int BASE_W  = ADDR_W - MIN_LOG2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [CFG_AW-1:0]                  cfg_sel,
  input  logic [ADDR_W-1:0]                  cfg_wdata,
  output logic [NUM_WIN:0][CTRL_W-1:0]       ctrl_set,
  output logic [NUM_WIN-1:0][BASE_W-1:0]     win_base,
  output logic [NUM_WIN-1:0][SZ_W-1:0]       win_sz,
  output logic [NUM_WIN-1:0]                 win_en,
  output logic                               cs_align
);
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[MIN_LOG2-1:SEL_EN_BIT+1];

  for (genvar k = 0; k <= NUM_WIN; k++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_set[k] <= RST_CTRL;
      else if (cfg_we && cfg_sel == CFG_AW'(k))
        ctrl_set[k] <= cfg_wdata[CTRL_W-1:0];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [CFG_AW-1:0] WADDR = CFG_AW'(CFG_WIN_BASE + w);
    always_ff @(posedge clk) begin
      if (rst) begin
        win_base[w] <= '0;
        win_sz[w]   <= '0;
        win_en[w]   <= 1'b0;
      end else if (cfg_we && cfg_sel == WADDR) begin
        win_base[w] <= cfg_wdata[ADDR_W-1:MIN_LOG2];
        win_sz[w]   <= cfg_wdata[SZ_W-1:0];
        win_en[w]   <= cfg_wdata[SEL_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cs_align <= 1'b0;
    else if (cfg_we && cfg_sel == CFG_OPT_ADDR)
      cs_align <= cfg_wdata[0];
  end
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 12,
  localparam int BASE_W  = ADDR_W - MIN_LOG2,
  localparam int IDX_W   = $clog2(NUM_WIN + 1)
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0][BASE_W-1:0] win_base,
  input  logic [NUM_WIN-1:0][SZ_W-1:0]   win_sz,
  input  logic [NUM_WIN-1:0]             win_en,
  output logic [NUM_WIN-1:0]             hit,
  output logic [IDX_W-1:0]               pick
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [BASE_W-1:0] keep;
    always_comb begin
      for (int b = 0; b < BASE_W; b++)
        keep[b] = (b >= int'(win_sz[w]));
    end
    assign hit[w] = win_en[w] &&
                    (((addr[ADDR_W-1:MIN_LOG2] ^ win_base[w]) & keep) == '0);
  end

  // fixed order: a higher window index overrides every lower one
  always_comb begin
    pick = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (hit[w]) pick = IDX_W'(w + 1);
  end
endmodule

// File: rtl/addr_win_csgen.sv
module addr_win_csgen #(
  parameter int NUM_CS = 5,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [IDX_W-1:0]  idx,
  input  logic              long_stb,
  input  logic              align,
  output logic [NUM_CS-1:0] cs_n,
  output logic              lat_stb
);
  logic [NUM_CS-1:0] cs_rise;
  logic [NUM_CS-1:0] cs_fall;
  logic              stb_ext;

  always_ff @(posedge clk) begin
    if (rst)
      cs_rise <= '1;
    else if (start)
      cs_rise <= ~(NUM_CS'(1) << idx);
    else if (stop)
      cs_rise <= '1;
  end

  // half-cycle-late copy for the default edge placement
  always_ff @(negedge clk) begin
    if (rst)
      cs_fall <= '1;
    else
      cs_fall <= cs_rise;
  end

  assign cs_n = align ? cs_rise : cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_stb <= 1'b0;
      stb_ext <= 1'b0;
    end else if (start) begin
      lat_stb <= 1'b1;
      stb_ext <= long_stb;
    end else if (stop) begin
      lat_stb <= 1'b0;
      stb_ext <= 1'b0;
    end else if (stb_ext) begin
      stb_ext <= 1'b0;
    end else begin
      lat_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 12,
  parameter logic [CTRL_W-1:0] RST_CTRL = 9'h00F,
  localparam int IDX_W   = $clog2(NUM_WIN + 1),
  localparam int BASE_W  = ADDR_W - MIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_start,
  input  logic              acc_end,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [CTRL_W-1:0] sel_ctrl,
  output logic              lat_stb,
  output logic [NUM_WIN:0]  cs_n
);
  logic [NUM_WIN:0][CTRL_W-1:0]   ctrl_set;
  logic [NUM_WIN-1:0][BASE_W-1:0] win_base;
  logic [NUM_WIN-1:0][SZ_W-1:0]   win_sz;
  logic [NUM_WIN-1:0]             win_en;
  logic                           cs_align;
  logic [NUM_WIN-1:0]             win_hit;
  logic [IDX_W-1:0]               pick;
  bus_ctrl_t                      pick_ctrl;

  addr_win_regs #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .RST_CTRL(RST_CTRL)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_set(ctrl_set), .win_base(win_base), .win_sz(win_sz), .win_en(win_en),
    .cs_align(cs_align)
  );

  addr_win_match #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2)
  ) u_match (
    .addr(acc_addr), .win_base(win_base), .win_sz(win_sz), .win_en(win_en),
    .hit(win_hit), .pick(pick)
  );

  assign pick_ctrl = bus_ctrl_t'(ctrl_set[pick]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx  <= '0;
      sel_ctrl <= RST_CTRL;
    end else if (acc_start) begin
      sel_idx  <= pick;
      sel_ctrl <= pick_ctrl;
    end
  end

  addr_win_csgen #(.NUM_CS(NUM_WIN + 1)) u_cs (
    .clk(clk), .rst(rst), .start(acc_start), .stop(acc_end), .idx(pick),
    .long_stb(pick_ctrl.long_stb), .align(cs_align), .cs_n(cs_n), .lat_stb(lat_stb)
  );
endmodule

// File: rtl/addr_window_cs_chk.sv
module addr_window_cs_chk #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_start,
  input logic             acc_end,
  input logic [NUM_WIN-1:0] win_hit,
  input logic [IDX_W-1:0] sel_idx,
  input logic             lat_stb,
  input logic [NUM_WIN:0] cs_n
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n == '1 && !lat_stb && sel_idx == '0));

  p_hit_selects_window_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_start && win_hit != '0) |=> sel_idx != '0);

  p_default_set_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_start && win_hit == '0) |=> (sel_idx == '0 && !cs_n[0]));

  p_top_window_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_start && win_hit[NUM_WIN-1]) |=> sel_idx == IDX_W'(NUM_WIN));

  p_single_cs_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  p_hold_sel_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_start |=> $stable(sel_idx));

  p_cs_follows_start_r7: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> (cs_n != '1 && !cs_n[sel_idx]));

  p_end_releases_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_end && !acc_start) |=> (cs_n == '1 && !lat_stb));

  p_strobe_rises_r9: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> lat_stb);

  p_strobe_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_stb) |-> $past(acc_start));
endmodule

bind addr_window_cs addr_window_cs_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .acc_start(acc_start), .acc_end(acc_end),
  .win_hit(win_hit), .sel_idx(sel_idx), .lat_stb(lat_stb), .cs_n(cs_n)
);

// File: tb/test_addr_window_cs.sv
module test_addr_window_cs;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_start = 1'b0;
  logic          acc_end = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    sel_idx;
  logic [8:0]    sel_ctrl;
  logic          lat_stb;
  logic [4:0]    cs_n;

  int checks = 0;
  int fails  = 0;

  logic [8:0]    ctrl_m [0:4];
  logic [AW-1:0] base_m [0:3];
  int            sz_m   [0:3];
  bit            en_m   [0:3];
  bit            align_m;

  always #10 clk = ~clk;

  addr_window_cs i_addr_window_cs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_start(acc_start), .acc_end(acc_end), .acc_addr(acc_addr),
    .sel_idx(sel_idx), .sel_ctrl(sel_ctrl), .lat_stb(lat_stb), .cs_n(cs_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win_in(int w, logic [AW-1:0] a);
    for (int b = 12; b < AW; b++)
      if ((b - 12) >= sz_m[w] && a[b] !== base_m[w][b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_sel(logic [AW-1:0] a);
    int r = 0;
    for (int w = 0; w < 4; w++)
      if (en_m[w] && win_in(w, a)) r = w + 1;
    return r;
  endfunction

  task automatic cfg_write(input logic [3:0] sel, input logic [AW-1:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input int k, input logic [8:0] v);
    cfg_write(4'(k), AW'(v));
    ctrl_m[k] = v;
  endtask

  // window w is 1..4, register address 8+(w-1)
  task automatic set_win(input int w, input logic [AW-1:0] base, input int sz, input bit en);
    cfg_write(4'(7 + w), {base[AW-1:12], 7'b0, en, 4'(sz)});
    base_m[w-1] = {base[AW-1:12], 12'h000};
    sz_m[w-1] = sz;
    en_m[w-1] = en;
  endtask

  task automatic set_align(input bit a);
    cfg_write(4'd7, AW'(a));
    align_m = a;
  endtask

  task automatic do_access(input logic [AW-1:0] a);
    int e;
    logic [4:0] ecs;
    bit lng;
    e = exp_sel(a);
    ecs = ~(5'b1 << e);
    lng = ctrl_m[e][5];
    @(posedge clk); #2;
    acc_start = 1'b1; acc_addr = a;
    @(posedge clk); #2;
    acc_start = 1'b0;
    #3;
    check("R4 R2 sel_idx", 32'(sel_idx), 32'(e));
    check("R5 sel_ctrl", 32'(sel_ctrl), 32'(ctrl_m[e]));
    check("R9 strobe rise", 32'(lat_stb), 32'd1);
    if (align_m) check("R7 cs on rising edge", 32'(cs_n), 32'(ecs));
    else         check("R6 cs not before falling edge", 32'(cs_n), 32'h1f);
    #10;
    check("R6 cs after falling edge", 32'(cs_n), 32'(ecs));
    @(posedge clk); #5;
    check("R9 strobe length", 32'(lat_stb), 32'(lng));
    check("R5 cs held", 32'(cs_n), 32'(ecs));
    #2; acc_end = 1'b1;
    @(posedge clk); #5;
    check("R8 strobe idle", 32'(lat_stb), 32'd0);
    if (align_m) check("R8 R7 release", 32'(cs_n), 32'h1f);
    else         check("R8 R6 release late", 32'(cs_n), 32'(ecs));
    #2; acc_end = 1'b0;
    #8;
    check("R8 released", 32'(cs_n), 32'h1f);
  endtask

  initial begin : watchdog
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1a7c));
    for (int k = 0; k < 5; k++) ctrl_m[k] = 9'h00F;
    for (int w = 0; w < 4; w++) begin base_m[w] = '0; sz_m[w] = 0; en_m[w] = 0; end
    align_m = 0;

    repeat (3) @(posedge clk);
    #5;
    check("R1 cs idle in reset", 32'(cs_n), 32'h1f);
    check("R1 strobe low in reset", 32'(lat_stb), 32'd0);
    #2; rst = 1'b0;
    @(posedge clk); #5;
    check("R1 sel_idx after reset", 32'(sel_idx), 32'd0);
    check("R1 sel_ctrl after reset", 32'(sel_ctrl), 32'h00F);
    check("R1 cs after reset", 32'(cs_n), 32'h1f);

    // R3: nothing enabled
    do_access(24'h123456);

    // R10 / R5: distinct control sets, including READY bits and long strobe
    set_ctrl(0, 9'h101);
    set_ctrl(1, 9'h082);
    set_ctrl(2, 9'h1A3);
    set_ctrl(3, 9'h014);
    set_ctrl(4, 9'h0C5);

    // R2 boundaries and R4 overlap 2 over 1
    set_win(1, 24'h010000, 4, 1);
    set_win(2, 24'h018000, 0, 1);
    do_access(24'h018ABC);
    do_access(24'h01F000);
    do_access(24'h020000);
    do_access(24'h00FFFF);
    do_access(24'h010000);

    // R2: base low bits ignored (acts as 0x100000, 1 MB)
    set_win(3, 24'h123000, 8, 1);
    do_access(24'h1FFFFF);
    do_access(24'h200000);
    // R4: 4 over 1 across groups, 4 over 3
    set_win(4, 24'h010000, 0, 1);
    do_access(24'h010800);
    set_win(4, 24'h100000, 1, 1);
    do_access(24'h101FFF);
    // R2: whole-space window
    set_win(4, 24'h000000, 12, 1);
    do_access(24'hFEDCBA);
    do_access(24'h018000);
    // R2: disabled window never matches
    set_win(4, 24'h000000, 12, 0);
    do_access(24'hFEDCBA);

    // R7 aligned edges
    set_align(1);
    do_access(24'h018000);
    do_access(24'h700000);

    // R10: unmapped addresses ignored
    cfg_write(4'd5, 24'hFFFFFF);
    cfg_write(4'd6, 24'hFFFFFF);
    cfg_write(4'd12, 24'hFFFFFF);
    cfg_write(4'd15, 24'hFFFFFF);
    do_access(24'h700000);
    do_access(24'h018123);
    do_access(24'h011000);

    // R8: start wins over a simultaneous end
    @(posedge clk); #2;
    acc_start = 1'b1; acc_end = 1'b1; acc_addr = 24'h010000;
    @(posedge clk); #2;
    acc_start = 1'b0; acc_end = 1'b0;
    #13;
    check("R8 start beats end", 32'(cs_n), 32'h1d);
    @(posedge clk); #2; acc_end = 1'b1;
    @(posedge clk); #2; acc_end = 1'b0;
    #13;
    check("R8 end after overlap", 32'(cs_n), 32'h1f);

    // random windows, sets, edge option and addresses
    for (int it = 0; it < 80; it++) begin
      if (it % 8 == 0) begin
        set_win(($urandom % 4) + 1, AW'($urandom & 32'h03F000), $urandom % 6, ($urandom % 4) != 0);
        set_ctrl($urandom % 5, 9'($urandom));
        set_align(1'($urandom));
      end
      begin
        int w = $urandom % 4;
        logic [AW-1:0] a;
        if (($urandom % 2) == 1 && sz_m[w] < 12)
          a = base_m[w] ^ (AW'($urandom) & ((AW'(1) << (12 + sz_m[w])) - 1));
        else
          a = AW'($urandom & 32'h03FFFF);
        do_access(a);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule